// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a small sum-of-products logic device. Eight product terms arrive from the AND array. A three-bit configuration selects what the cell does with them: it can register their OR, drive it straight to the pin, give the pin up as an input, or run as a bidirectional pin whose eighth term controls the tri-state. The three configuration bits are two device-wide global bits and one local bit. A per-cell polarity bit can invert the result. The cell drives a pad model, which is a data value plus an enable, and it returns one feedback bit to the array.

One configuration word drives all four internal selections at the same time: the OR width, the data path, the enable source and the feedback source. The end cells of a device and the cells with no combinational feedback are built from the same source through parameters. For test, the register can be preloaded with any state. After reset the register is clear, so a registered pin reads high.

Top module: `pld_macrocell`

## Requirements
- R1: The configuration is (g0 = `glb_i[0]`, g1 = `glb_i[1]`, local = `loc_i`). On every rising clock edge the register captures (OR of the terms) XOR `pol_i`. The OR covers all eight terms, or `pterm_i[6:0]` when the configuration is combinational I/O.
- R2: With (0,1,0), the cell is registered. From the second edge after reset, `pad_o` shows the value captured at the previous edge, and `pad_oe_o` equals `oe_i`.
- R3: With (1,0,0), the cell is a combinational output. `pad_o` = OR of all eight terms XOR `pol_i`, and `pad_oe_o` = 1 in the same cycle.
- R4: With (1,0,1), the cell is a dedicated input. `pad_oe_o` = 0 and `pad_o` = 0.
- R5: With (1,1,1) or (0,1,1), the cell is combinational I/O. `pad_o` = OR of `pterm_i[6:0]` XOR `pol_i`, and `pad_oe_o` = `pterm_i[7]`.
- R6: The unlisted configurations (0,0,0), (0,0,1) and (1,1,0) behave like a dedicated input, with `pad_oe_o` = 0 and `pad_o` = 0.
- R7: The feedback is selected by {s, local}, where s = g1: 10 gives the registered pin value, 01 gives `adj_pin_i`, and 00 or 11 gives `pin_i`.
- R8: With `END_CELL`=1, s is g0 instead of g1. With `NO_COMB_FB`=1, `fb_o` = 0 in the (1,0,0) configuration.
- R9: While `rst_ni` is low the register is clear, and a registered `pad_o` reads 1 whatever the value of `pol_i`.
- R10: A high `preload_i` at a clock edge loads the register so that the registered `pad_o` then equals `preload_val_i`. This takes priority over the normal capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pterm_i | input | 8 | Product terms from the array |
| oe_i | input | 1 | Shared output enable for registered cells |
| glb_i | input | 2 | Global mode bits g0 (bit 0) and g1 (bit 1) |
| loc_i | input | 1 | Local mode bit |
| pol_i | input | 1 | Polarity, 1 inverts |
| preload_i | input | 1 | Register preload strobe |
| preload_val_i | input | 1 | Pin value to preload |
| pin_i | input | 1 | Value read back from the own pin |
| adj_pin_i | input | 1 | Value of the adjacent cell's pin |
| pad_o | output | 1 | Pad data |
| pad_oe_o | output | 1 | Pad tri-state enable |
| fb_o | output | 1 | Feedback to the array |

## Verification
The assertions check on every cycle that the enable source matches the decoded mode. They also check that input and unlisted modes never drive the pad, that a registered pin shows the previous edge's capture, and that a preload wins over capture. Three behaviours can only be shown by the bench scenarios. The first is the feedback selection, including the end-cell and no-feedback variants, which the bench exercises on a second instance. The second is the reset value under both polarities. The third is the register continuing to capture while the cell sits in a combinational mode, which becomes visible only when the bench switches back to registered mode.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  typedef enum logic [1:0] {
    MC_REG  = 2'd0,
    MC_COUT = 2'd1,
    MC_DIN  = 2'd2,
    MC_CIO  = 2'd3
  } mc_mode_e;

  localparam int unsigned N_PTERM = 8;
endpackage

// File: rtl/pld_mc_decode.sv
module pld_mc_decode
  import pld_mc_pkg::*;
(
  input  logic [1:0] glb_i,
  input  logic       loc_i,
  output mc_mode_e   mode_o
);
  always_comb begin
    unique case ({glb_i[0], glb_i[1], loc_i})
      3'b010:         mode_o = MC_REG;
      3'b100:         mode_o = MC_COUT;
      3'b111, 3'b011: mode_o = MC_CIO;
      default:        mode_o = MC_DIN;  // incl. unlisted combos: pad never driven
    endcase
  end
endmodule

// File: rtl/pld_mc_sum.sv
module pld_mc_sum
  import pld_mc_pkg::*;
#(
  parameter int unsigned N_PT = N_PTERM
) (
  input  logic [N_PT-1:0] pterm_i,
  input  mc_mode_e        mode_i,
  input  logic            pol_i,
  output logic            sum_o
);
  localparam int unsigned N_NARROW = N_PT - 1;

  logic or_narrow, or_wide;

  always_comb begin
    or_narrow = 1'b0;
    for (int i = 0; i < N_NARROW; i++) or_narrow |= pterm_i[i];
    or_wide = or_narrow | pterm_i[N_PT-1];
  end

  // top term becomes the enable in combinational I/O mode
  assign sum_o = ((mode_i == MC_CIO) ? or_narrow : or_wide) ^ pol_i;
endmodule

// File: rtl/pld_mc_fb.sv
module pld_mc_fb
  import pld_mc_pkg::*;
#(
  parameter bit END_CELL   = 1'b0,
  parameter bit NO_COMB_FB = 1'b0
) (
  input  logic [1:0] glb_i,
  input  logic       loc_i,
  input  mc_mode_e   mode_i,
  input  logic       reg_val_i,
  input  logic       pin_i,
  input  logic       adj_pin_i,
  output logic       fb_o
);
  logic sel_g;
  logic fb_mux;

  generate
    if (END_CELL) begin : g_end
      assign sel_g = glb_i[0];
    end else begin : g_mid
      assign sel_g = glb_i[1];
    end
  endgenerate

  always_comb begin
    unique case ({sel_g, loc_i})
      2'b10:   fb_mux = reg_val_i;
      2'b01:   fb_mux = adj_pin_i;
      default: fb_mux = pin_i;
    endcase
  end

  generate
    if (NO_COMB_FB) begin : g_nofb
      assign fb_o = (mode_i == MC_COUT) ? 1'b0 : fb_mux;
    end else begin : g_fb
      assign fb_o = fb_mux;
    end
  endgenerate
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter bit END_CELL   = 1'b0,
  parameter bit NO_COMB_FB = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PTERM-1:0] pterm_i,
  input  logic               oe_i,
  input  logic [1:0]         glb_i,
  input  logic               loc_i,
  input  logic               pol_i,
  input  logic               preload_i,
  input  logic               preload_val_i,
  input  logic               pin_i,
  input  logic               adj_pin_i,
  output logic               pad_o,
  output logic               pad_oe_o,
  output logic               fb_o
);
  mc_mode_e mode;
  logic     sum;
  logic     q;       // flop output, clears low
  logic     reg_pad; // registered value as seen at the pin

  pld_mc_decode u_dec (.glb_i(glb_i), .loc_i(loc_i), .mode_o(mode));

  pld_mc_sum #(.N_PT(N_PTERM)) u_sum (
    .pterm_i(pterm_i), .mode_i(mode), .pol_i(pol_i), .sum_o(sum)
  );

  // pin shows inverted Q: cleared flop reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= 1'b0;
    else if (preload_i) q <= ~preload_val_i;
    else                q <= ~sum;
  end
  assign reg_pad = ~q;

  always_comb begin
    unique case (mode)
      MC_REG:  begin pad_o = reg_pad; pad_oe_o = oe_i;             end
      MC_COUT: begin pad_o = sum;     pad_oe_o = 1'b1;             end
      MC_CIO:  begin pad_o = sum;     pad_oe_o = pterm_i[N_PTERM-1]; end
      default: begin pad_o = 1'b0;    pad_oe_o = 1'b0;             end
    endcase
  end

  pld_mc_fb #(.END_CELL(END_CELL), .NO_COMB_FB(NO_COMB_FB)) u_fb (
    .glb_i(glb_i), .loc_i(loc_i), .mode_i(mode), .reg_val_i(reg_pad),
    .pin_i(pin_i), .adj_pin_i(adj_pin_i), .fb_o(fb_o)
  );

  a_r2_reg_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(preload_i) && mode == MC_REG) |-> pad_o == $past(sum));
  a_r10_preload_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(preload_i) && mode == MC_REG) |-> pad_o == $past(preload_val_i));
  a_r2_reg_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_i == 2'b10 && !loc_i) |-> pad_oe_o == oe_i);
  a_r3_cout_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_i == 2'b01 && !loc_i) |-> pad_oe_o);
  a_r4_din_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_i == 2'b01 && loc_i) |-> (!pad_oe_o && !pad_o));
  a_r5_cio_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_i[1] && loc_i) |-> pad_oe_o == pterm_i[N_PTERM-1]);
  a_r6_undef_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_i == 2'b00 || (glb_i == 2'b11 && !loc_i)) |-> (!pad_oe_o && !pad_o));
endmodule

// File: tb/pld_macrocell_tb.sv
module pld_macrocell_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pt = '0;
  logic       oe = 1'b0, g0 = 1'b0, g1 = 1'b1, loc = 1'b0, pol = 1'b0;
  logic       pre = 1'b0, pre_v = 1'b0, pin = 1'b0, adj = 1'b0;
  logic       pad_a, oe_a, fb_a, pad_b, oe_b, fb_b;

  int checks = 0, fails = 0;
  bit model_reg = 1'b1;   // registered pin value (shared by both instances)
  bit last_pre  = 1'b0;

  always #10ns clk = ~clk;  // 50 MHz

  pld_macrocell dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pterm_i(pt), .oe_i(oe), .glb_i({g1, g0}),
    .loc_i(loc), .pol_i(pol), .preload_i(pre), .preload_val_i(pre_v),
    .pin_i(pin), .adj_pin_i(adj), .pad_o(pad_a), .pad_oe_o(oe_a), .fb_o(fb_a)
  );

  pld_macrocell #(.END_CELL(1'b1), .NO_COMB_FB(1'b1)) dut_end_i (
    .clk_i(clk), .rst_ni(rst_n), .pterm_i(pt), .oe_i(oe), .glb_i({g1, g0}),
    .loc_i(loc), .pol_i(pol), .preload_i(pre), .preload_val_i(pre_v),
    .pin_i(pin), .adj_pin_i(adj), .pad_o(pad_b), .pad_oe_o(oe_b), .fb_o(fb_b)
  );

  // 0 reg, 1 comb out, 2 input/unlisted, 3 comb I/O
  function automatic int kind();
    if (!g0 && g1 && !loc) return 0;
    if (g0 && !g1 && !loc) return 1;
    if (g1 && loc)         return 3;
    return 2;
  endfunction

  function automatic bit cur_sum();
    return ((kind() == 3) ? |pt[6:0] : |pt) ^ pol;
  endfunction

  function automatic bit exp_fb(bit is_end);
    bit s = is_end ? g0 : g1;
    if (is_end && kind() == 1) return 1'b0;
    if (s && !loc) return model_reg;
    if (!s && loc) return adj;
    return pin;
  endfunction

  task automatic chk(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b (cfg %0b%0b%0b)", req, act, exp, g0, g1, loc);
    end
  endtask

  task automatic compare_all();
    bit e_pad, e_oe;
    string tp;
    case (kind())
      0: begin e_pad = model_reg; e_oe = oe; tp = last_pre ? "R10" : "R1/R2"; end
      1: begin e_pad = cur_sum(); e_oe = 1'b1; tp = "R3"; end
      3: begin e_pad = cur_sum(); e_oe = pt[7]; tp = "R5"; end
      default: begin e_pad = 1'b0; e_oe = 1'b0; tp = (g0 && !g1) ? "R4" : "R6"; end
    endcase
    chk(tp, pad_a, e_pad);
    chk(tp, oe_a, e_oe);
    chk(tp, pad_b, e_pad);
    chk(tp, oe_b, e_oe);
    chk("R7", fb_a, exp_fb(1'b0));
    chk("R8", fb_b, exp_fb(1'b1));
  endtask

  // reference register: R1 capture every edge, R10 preload first
  always @(posedge clk) begin
    if (!rst_n) model_reg <= 1'b1;
    else begin
      last_pre  <= pre;
      model_reg <= pre ? pre_v : cur_sum();
    end
  end

  task automatic cycle(bit a0, bit a1, bit l, bit do_pre);
    @(negedge clk);
    g0 = a0; g1 = a1; loc = l;
    pt = 8'($urandom & $urandom);
    pol = 1'($urandom); oe = 1'($urandom); pin = 1'($urandom); adj = 1'($urandom);
    pre = do_pre; pre_v = 1'($urandom);
    #2ns;
    compare_all();
  endtask

  initial begin : watchdog
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R9: reset state under both polarities, registered config
    g0 = 0; g1 = 1; loc = 0;
    for (int p = 0; p < 2; p++) begin
      pol = 1'(p); pt = 8'hFF; #5ns;
      chk("R9", pad_a, 1'b1);
      chk("R9", pad_b, 1'b1);
    end
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // directed sweep of every configuration
    for (int c = 0; c < 8; c++)
      for (int k = 0; k < 6; k++) cycle(c[2], c[1], c[0], 1'b0);
    // registered with preloads (R10)
    for (int k = 0; k < 20; k++) cycle(1'b0, 1'b1, 1'b0, k[0]);
    // captures during comb modes, then back to registered (R1)
    for (int k = 0; k < 10; k++) begin
      cycle(1'b1, 1'b1, 1'b1, 1'b0);
      cycle(1'b0, 1'b1, 1'b0, 1'b0);
    end
    // random mix
    for (int k = 0; k < 2000; k++)
      cycle(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 5) == 0);

    // R9: reset mid-run clears the register
    @(negedge clk); g0 = 0; g1 = 1; loc = 0; pol = 1; rst_n = 1'b0; #2ns;
    chk("R9", pad_a, 1'b1);
    chk("R9", pad_b, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule